// File: doc/BRIEF.md
# Three-Share Masked Bitwise Logic Unit

This block computes a bitwise AND, OR or XOR of two operands. Each operand is held as three XOR shares, and the unit never combines them into the plain value. Each share pair is WIDTH bits wide. An operand equals the XOR of its three shares. The result also leaves the block as three shares, and their XOR is the operation applied to the plain operands. Output share 0 is formed by logic that never reads input share 0. The same holds for share 1 and share 2. A glitch inside one component therefore cannot combine all three shares of a secret.

The nonlinear operations (AND, and OR built from AND by De Morgan) cannot keep a uniform output sharing on their own. The block adds a mask to each output share, and the three masks XOR to zero. Each mask is built from an input-share bit at another bit position plus the two fresh random bits on `rnd`. XOR is done share by share and uses no randomness. All three output shares go through registers, so a result appears one clock after its inputs.

Top module: `tri_share_logic`

## Requirements
- R1: While `rst_n` is low, and after release until the first capturing edge, all three output shares are zero.
- R2: The inputs present at a rising clock edge appear at the outputs after that edge. The outputs do not change between edges.
- R3: The XOR of `q_s0`, `q_s1` and `q_s2` equals the selected operation on the recombined operands: AND for `op` = 2'b00, OR for 2'b01, XOR for 2'b10. This holds for every sharing and every `rnd`.
- R4: For AND and OR, output share k (k = 0, 1, 2) does not depend on input share k of either operand.
- R5: For XOR (`op` = 2'b10), output share k equals x share k XOR y share k, and `rnd` has no effect.
- R6: For AND, bit i of the masks is as follows, with j = (i + ROT) mod WIDTH: share 0 gets `x_s1[j]` ^ `rnd[0]`, share 1 gets `x_s0[j]` ^ `rnd[1]`, and share 2 gets `x_s0[j]` ^ `x_s1[j]` ^ `rnd[0]` ^ `rnd[1]`. With all input shares zero, the outputs are therefore all bits `rnd[0]`, all bits `rnd[1]`, and all bits of their XOR.
- R7: The mask source index wraps around. With ROT = 1, bit WIDTH-1 draws its mask from bit 0.
- R8: `op` = 2'b11 clears all three output shares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 2 | 00 AND, 01 OR, 10 XOR, 11 clear |
| rnd | input | 2 | Fresh random bits; bit 0 is r1, bit 1 is r2 |
| x_s0 | input | WIDTH | Operand x, share 0 |
| x_s1 | input | WIDTH | Operand x, share 1 |
| x_s2 | input | WIDTH | Operand x, share 2 |
| y_s0 | input | WIDTH | Operand y, share 0 |
| y_s1 | input | WIDTH | Operand y, share 1 |
| y_s2 | input | WIDTH | Operand y, share 2 |
| q_s0 | output | WIDTH | Result share 0 (no input share 0 feeds it for AND/OR) |
| q_s1 | output | WIDTH | Result share 1 (no input share 1 feeds it for AND/OR) |
| q_s2 | output | WIDTH | Result share 2 (no input share 2 feeds it for AND/OR) |

## Verification
The bench builds the block with its defaults, WIDTH = 8 and ROT = 1. With ROT = 1, bit 7 takes its mask from bit 0. A single set share bit therefore shows the wrap-around directly, and all-zero sharings expose the raw masks. Eight-bit operands keep random sharings dense enough that every operand pattern class and every opcode is exercised many times. Non-completeness is probed by rewriting one input share index while the other two shares and `rnd` stay fixed.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
   typedef enum logic [1:0] {
      TSL_AND   = 2'b00,
      TSL_OR    = 2'b01,
      TSL_XOR   = 2'b10,
      TSL_CLEAR = 2'b11
   } tsl_op_e;

   localparam int TSL_SHARES = 3;
endpackage

// File: rtl/tsl_and_bit.sv
// One bit of the shared AND with its resharing masks.
// Component z0 never sees share 0, z1 never sees share 1, z2 never sees share 2.
module tsl_and_bit (
   input  logic x0,
   input  logic x1,
   input  logic x2,
   input  logic y0,
   input  logic y1,
   input  logic y2,
   input  logic x0_far,
   input  logic x1_far,
   input  logic r1,
   input  logic r2,
   output logic z0,
   output logic z1,
   output logic z2
);
   logic m0, m1, m2;

   // masks built from other bit positions; m0 ^ m1 ^ m2 == 0
   assign m0 = x1_far ^ r1;
   assign m1 = x0_far ^ r2;
   assign m2 = x0_far ^ x1_far ^ r1 ^ r2;

   assign z0 = (x1 & y1) ^ (x1 & y2) ^ (x2 & y1) ^ m0;
   assign z1 = (x2 & y2) ^ (x0 & y2) ^ (x2 & y0) ^ m1;
   assign z2 = (x0 & y0) ^ (x0 & y1) ^ (x1 & y0) ^ m2;
endmodule

// File: rtl/tsl_and_vec.sv
// Vector of shared AND bits; mask sources rotated by ROT positions.
module tsl_and_vec #(
   parameter int WIDTH = 8,
   parameter int ROT   = 1
) (
   input  logic [WIDTH-1:0] x0,
   input  logic [WIDTH-1:0] x1,
   input  logic [WIDTH-1:0] x2,
   input  logic [WIDTH-1:0] y0,
   input  logic [WIDTH-1:0] y1,
   input  logic [WIDTH-1:0] y2,
   input  logic [1:0]       rnd,
   output logic [WIDTH-1:0] z0,
   output logic [WIDTH-1:0] z1,
   output logic [WIDTH-1:0] z2
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int J = (i + ROT) % WIDTH;
      tsl_and_bit i_bit (
         .x0     (x0[i]),
         .x1     (x1[i]),
         .x2     (x2[i]),
         .y0     (y0[i]),
         .y1     (y1[i]),
         .y2     (y2[i]),
         .x0_far (x0[J]),
         .x1_far (x1[J]),
         .r1     (rnd[0]),
         .r2     (rnd[1]),
         .z0     (z0[i]),
         .z1     (z1[i]),
         .z2     (z2[i])
      );
   end
endmodule

// File: rtl/tsl_share_regs.sv
// Output registers, one bank per share, asynchronous active-low clear.
module tsl_share_regs #(
   parameter int WIDTH  = 8,
   parameter int SHARES = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SHARES-1:0][WIDTH-1:0] d,
   output logic [SHARES-1:0][WIDTH-1:0] q
);
   for (genvar s = 0; s < SHARES; s++) begin : g_share
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[s] <= '0;
         else        q[s] <= d[s];
      end
   end
endmodule

// File: rtl/tri_share_logic.sv
module tri_share_logic #(
   parameter int WIDTH = 8,
   parameter int ROT   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       op,
   input  logic [1:0]       rnd,
   input  logic [WIDTH-1:0] x_s0,
   input  logic [WIDTH-1:0] x_s1,
   input  logic [WIDTH-1:0] x_s2,
   input  logic [WIDTH-1:0] y_s0,
   input  logic [WIDTH-1:0] y_s1,
   input  logic [WIDTH-1:0] y_s2,
   output logic [WIDTH-1:0] q_s0,
   output logic [WIDTH-1:0] q_s1,
   output logic [WIDTH-1:0] q_s2
);
   import tsl_pkg::*;

   localparam int NS = TSL_SHARES;

   if (WIDTH < 2) begin : g_bad_width
      $error("tri_share_logic: WIDTH must be at least 2");
   end
   if (ROT < 1 || ROT >= WIDTH) begin : g_bad_rot
      $error("tri_share_logic: ROT must lie in 1..WIDTH-1");
   end

   tsl_op_e op_e;
   logic    or_sel;
   logic [WIDTH-1:0] ax0, ay0;
   logic [WIDTH-1:0] z0, z1, z2;
   logic [NS-1:0][WIDTH-1:0] nxt, cur;

   assign op_e   = tsl_op_e'(op);
   assign or_sel = (op_e == TSL_OR);

   // De Morgan: complement share 0 of each operand, and later of the result
   assign ax0 = x_s0 ^ {WIDTH{or_sel}};
   assign ay0 = y_s0 ^ {WIDTH{or_sel}};

   tsl_and_vec #(.WIDTH(WIDTH), .ROT(ROT)) i_and (
      .x0  (ax0),
      .x1  (x_s1),
      .x2  (x_s2),
      .y0  (ay0),
      .y1  (y_s1),
      .y2  (y_s2),
      .rnd (rnd),
      .z0  (z0),
      .z1  (z1),
      .z2  (z2)
   );

   always_comb begin
      unique case (op_e)
         TSL_AND: begin
            nxt[0] = z0;
            nxt[1] = z1;
            nxt[2] = z2;
         end
         TSL_OR: begin
            nxt[0] = ~z0;
            nxt[1] = z1;
            nxt[2] = z2;
         end
         TSL_XOR: begin
            nxt[0] = x_s0 ^ y_s0;
            nxt[1] = x_s1 ^ y_s1;
            nxt[2] = x_s2 ^ y_s2;
         end
         default: nxt = '0;
      endcase
   end

   tsl_share_regs #(.WIDTH(WIDTH), .SHARES(NS)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nxt),
      .q     (cur)
   );

   assign q_s0 = cur[0];
   assign q_s1 = cur[1];
   assign q_s2 = cur[2];
endmodule

// File: rtl/tri_share_logic_chk.sv
module tri_share_logic_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       op,
   input logic [WIDTH-1:0] x_s0,
   input logic [WIDTH-1:0] x_s1,
   input logic [WIDTH-1:0] x_s2,
   input logic [WIDTH-1:0] y_s0,
   input logic [WIDTH-1:0] y_s1,
   input logic [WIDTH-1:0] y_s2,
   input logic [WIDTH-1:0] q_s0,
   input logic [WIDTH-1:0] q_s1,
   input logic [WIDTH-1:0] q_s2
);
   logic armed;
   logic [WIDTH-1:0] xv, yv, qv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign xv = x_s0 ^ x_s1 ^ x_s2;
   assign yv = y_s0 ^ y_s1 ^ y_s2;
   assign qv = q_s0 ^ q_s1 ^ q_s2;

   AST_AND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op) == 2'b00 |-> qv == ($past(xv) & $past(yv))); // R3
   AST_OR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op) == 2'b01 |-> qv == ($past(xv) | $past(yv))); // R3
   AST_XOR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op) == 2'b10 |-> qv == ($past(xv) ^ $past(yv))); // R3
   AST_XOR_SHAREWISE: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op) == 2'b10 |-> q_s1 == ($past(x_s1) ^ $past(y_s1))); // R5
   AST_CLEAR_OP: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(op) == 2'b11 |-> (q_s0 | q_s1 | q_s2) == '0); // R8
endmodule

bind tri_share_logic tri_share_logic_chk #(.WIDTH(WIDTH)) i_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .op    (op),
   .x_s0  (x_s0),
   .x_s1  (x_s1),
   .x_s2  (x_s2),
   .y_s0  (y_s0),
   .y_s1  (y_s1),
   .y_s2  (y_s2),
   .q_s0  (q_s0),
   .q_s1  (q_s1),
   .q_s2  (q_s2)
);

// File: tb/test_tri_share_logic.sv
module test_tri_share_logic;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   op = 2'b00;
   logic [1:0]   rnd = 2'b00;
   logic [W-1:0] x_s0 = '0, x_s1 = '0, x_s2 = '0;
   logic [W-1:0] y_s0 = '0, y_s1 = '0, y_s2 = '0;
   logic [W-1:0] q_s0, q_s1, q_s2;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   tri_share_logic #(.WIDTH(W), .ROT(1)) i_tri_share_logic (
      .clk(clk), .rst_n(rst_n), .op(op), .rnd(rnd),
      .x_s0(x_s0), .x_s1(x_s1), .x_s2(x_s2),
      .y_s0(y_s0), .y_s1(y_s1), .y_s2(y_s2),
      .q_s0(q_s0), .q_s1(q_s1), .q_s2(q_s2)
   );

   function automatic logic [W-1:0] ref_op(input logic [1:0] o, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
      case (o)
         2'b00:   return a & b;
         2'b01:   return a | b;
         2'b10:   return a ^ b;
         default: return '0;
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive on the falling edge, sample 1 ns after the next rising edge
   task automatic apply(input logic [1:0] o, input logic [1:0] r,
                        input logic [W-1:0] a0, a1, a2, b0, b1, b2);
      @(negedge clk);
      op = o; rnd = r;
      x_s0 = a0; x_s1 = a1; x_s2 = a2;
      y_s0 = b0; y_s1 = b1; y_s2 = b2;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [W-1:0] ref0, xa, xb, xv, ya, yb, yv, prev;
      void'($urandom(32'h5eed1234));

      // R1 reset
      @(negedge clk);
      x_s0 = 8'h5a; y_s0 = 8'hc3;
      @(posedge clk); #1;
      check("R1 share0 in reset", q_s0, '0);
      check("R1 share1 in reset", q_s1, '0);
      check("R1 share2 in reset", q_s2, '0);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R1 all shares after release", q_s0 | q_s1 | q_s2, '0);

      // R6 raw masks: zero sharings, AND
      for (int r = 0; r < 4; r++) begin
         apply(2'b00, 2'(r), '0, '0, '0, '0, '0, '0);
         check("R6 mask share0", q_s0, {W{r[0]}});
         check("R6 mask share1", q_s1, {W{r[1]}});
         check("R6 mask share2", q_s2, {W{r[0] ^ r[1]}});
      end

      // R7 wrap-around: only x_s1 bit 0 set
      apply(2'b00, 2'b00, '0, 8'h01, '0, '0, '0, '0);
      check("R7 wrap share0", q_s0, 8'h80);
      check("R7 wrap share1", q_s1, 8'h00);
      check("R7 wrap share2", q_s2, 8'h80);

      // R8 clear
      apply(2'b11, 2'b11, 8'hff, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9a);
      check("R8 clear", q_s0 | q_s1 | q_s2, '0);

      // R4 non-completeness for AND and OR
      for (int o = 0; o < 2; o++) begin
         for (int k = 0; k < 3; k++) begin
            logic [W-1:0] s [6];
            logic [W-1:0] first;
            logic [1:0]   r;
            for (int m = 0; m < 6; m++) s[m] = W'($urandom);
            r = 2'($urandom);
            apply(2'(o), r, s[0], s[1], s[2], s[3], s[4], s[5]);
            first = (k == 0) ? q_s0 : (k == 1) ? q_s1 : q_s2;
            s[k] = ~s[k]; s[k+3] = s[k+3] ^ 8'h3c;
            apply(2'(o), r, s[0], s[1], s[2], s[3], s[4], s[5]);
            check("R4 share independent of own index",
                  (k == 0) ? q_s0 : (k == 1) ? q_s1 : q_s2, first);
         end
      end

      // R5 XOR share-wise, rnd ignored
      for (int n = 0; n < 20; n++) begin
         logic [W-1:0] a0, a1, a2, b0, b1, b2;
         a0 = W'($urandom); a1 = W'($urandom); a2 = W'($urandom);
         b0 = W'($urandom); b1 = W'($urandom); b2 = W'($urandom);
         apply(2'b10, 2'($urandom), a0, a1, a2, b0, b1, b2);
         check("R5 share0", q_s0, a0 ^ b0);
         check("R5 share1", q_s1, a1 ^ b1);
         check("R5 share2", q_s2, a2 ^ b2);
      end

      // R2 latency: outputs hold until the edge
      apply(2'b10, 2'b00, 8'h0f, '0, '0, 8'hf0, '0, '0);
      prev = q_s0;
      @(negedge clk);
      x_s0 = 8'h00; y_s0 = 8'h00;
      #1;
      check("R2 hold before edge", q_s0, prev);
      @(posedge clk); #1;
      check("R2 update after edge", q_s0, 8'h00);

      // R3 random sharings, all opcodes, with corner operands
      for (int n = 0; n < 600; n++) begin
         logic [1:0] o;
         o  = 2'(n % 3);
         case (n % 50)
            0: begin xv = '0;  yv = '1; end
            1: begin xv = '1;  yv = '1; end
            2: begin xv = 8'haa; yv = 8'h55; end
            default: begin xv = W'($urandom); yv = W'($urandom); end
         endcase
         xa = W'($urandom); xb = W'($urandom);
         ya = W'($urandom); yb = W'($urandom);
         apply(o, 2'($urandom), xa, xb, xv ^ xa ^ xb, ya, yb, yv ^ ya ^ yb);
         ref0 = ref_op(o, xv, yv);
         check("R3 recombined result", q_s0 ^ q_s1 ^ q_s2, ref0);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule